// File: doc/BRIEF.md
# Byte Channel Register Block

This block connects a processor bus to a pair of byte streams. Bytes that arrive on the inbound stream wait in a receive queue. Software collects them one at a time by reading the data word. Bytes that software writes to the data word go into a transmit queue, and the outbound stream drains that queue. Both streams use a valid/ready handshake.

A control word holds two interrupt enables and shows two pending flags. It also reports how many transmit slots are free, and carries a sticky activity flag. The activity flag records that the far side moved a byte; software clears it by writing a 1 to it.

Software uses the block as a simple console channel. It polls or takes the interrupt, drains received characters until the valid bit reads 0, and writes output characters while the reported free space allows.

Top module: `byte_chan_regs`

## Requirements
- R1: After reset both queues are empty, both enables and the activity flag are 0, `irq` is 0, `rx_ready` is 1 and `tx_valid` is 0.
- R2: A read of the data word (address bits [2]=0) with a byte queued returns the oldest byte in bits 7:0, 1 in bit 15, the number of bytes left after this read in bits 31:16, and 0 in bits 14:8. The read removes that byte from the queue.
- R3: A read of the data word with the receive queue empty returns all zeros, including bit 15, and leaves both queues unchanged.
- R4: A write to the data word appends bits 7:0 to the transmit queue. A write to a full transmit queue is dropped and the queue contents stay as they were.
- R5: `tx_valid` is 1 exactly when the transmit queue is non-empty. `tx_data` shows the oldest byte. A byte leaves the queue on a clock edge where `tx_valid` and `tx_ready` are both 1, and bytes leave in write order.
- R6: `rx_ready` is 1 exactly when the receive queue holds fewer than 64 bytes. A byte is taken only on an edge with `rx_valid` and `rx_ready` both 1.
- R7: A write to the control word (address bits [2]=1) loads the read enable from bit 0 and the write enable from bit 1. Both read back in the same positions.
- R8: Read pending (control bit 8) is the read enable ANDed with a non-empty receive queue. Write pending (bit 9) is the write enable ANDed with at least 32 free transmit slots. `irq` is the OR of the two.
- R9: The activity flag (control bit 10) sets on any edge that accepts a byte on either stream. A control write with bit 10 = 1 clears it. If both happen on the same edge, the flag is set.
- R10: Control bits 31:16 report 64 minus the transmit queue occupancy. Bits 7:2 and 15:11 read 0.
- R11: A control read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Bus access strobe, one access per cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Byte address: 0 = data word, 4 = control word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid in the cycle of the access |
| rx_valid | input | 1 | Inbound byte offered |
| rx_data | input | 8 | Inbound byte |
| rx_ready | output | 1 | Receive queue can take a byte |
| tx_valid | output | 1 | Outbound byte available |
| tx_data | output | 8 | Outbound byte |
| tx_ready | input | 1 | Far side takes the outbound byte |
| irq | output | 1 | Interrupt request |

## Verification
Each cycle the bench compares the handshake outputs and `irq` with a reference queue model. Because of this, a wrong occupancy or a wrong pointer shows up within one cycle, either as a wrong `rx_ready` or `tx_valid` level or as a wrong `irq`. A lost, duplicated or reordered byte appears at the next data read or the next outbound transfer as a byte or count mismatch. A stale activity flag or enable bit appears at the next control read.

// File: rtl/byte_chan_pkg.sv
package byte_chan_pkg;
   localparam int CHAR_W      = 8;
   localparam int WORD_W      = 32;
   localparam int VALID_BIT   = 15;
   localparam int CNT_LSB     = 16;
   localparam int EN_RD_BIT   = 0;
   localparam int EN_WR_BIT   = 1;
   localparam int PEND_RD_BIT = 8;
   localparam int PEND_WR_BIT = 9;
   localparam int ACT_BIT     = 10;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/char_fifo.sv
module char_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   initial begin
      if (DEPTH < 2) $error("char_fifo: DEPTH must be at least 2");
      if (DW < 1)    $error("char_fifo: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(count));
   assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> $stable(count) && $stable(rd_ptr));
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic [2:0] wr_bits,
   input  logic       activity,
   output logic       en_rd,
   output logic       en_wr,
   output logic       act_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_rd    <= 1'b0;
         en_wr    <= 1'b0;
         act_flag <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_rd <= wr_bits[0];
            en_wr <= wr_bits[1];
         end
         if (activity)                  act_flag <= 1'b1;
         else if (ctrl_wr && wr_bits[2]) act_flag <= 1'b0;
      end
   end

   assert_act_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      activity |=> act_flag);
   assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable({en_rd, en_wr}));
endmodule

// File: rtl/chan_irq.sv
module chan_irq #(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          en_rd,
   input  logic          en_wr,
   input  logic          rx_empty,
   input  logic [CW-1:0] tx_count,
   output logic [CW-1:0] tx_free,
   output logic          pend_rd,
   output logic          pend_wr,
   output logic          irq
);
   assign tx_free = CW'(DEPTH) - tx_count;
   assign pend_rd = en_rd && !rx_empty;
   assign pend_wr = en_wr && (tx_free >= CW'(DEPTH / 2));
   assign irq     = pend_rd || pend_wr;
endmodule

// File: rtl/byte_chan_regs.sv
module byte_chan_regs
   import byte_chan_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 3,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_data,
   input  logic              tx_ready,
   output logic              irq
);
   initial begin
      if (DEPTH > 65535) $error("byte_chan_regs: count field is 16 bits");
      if (ADDR_W < 3)    $error("byte_chan_regs: ADDR_W must cover offset 4");
   end

   reg_sel_e          sel;
   logic [CW-1:0]     rx_count, tx_count, tx_free;
   logic              rx_full, rx_empty, tx_full, tx_empty;
   logic [CHAR_W-1:0] rx_head;
   logic              rx_pop, tx_push, rx_take, tx_give;
   logic              en_rd, en_wr, act_flag, pend_rd, pend_wr;
   logic [15:0]       ravail;

   always_comb begin
      sel = SEL_NONE;
      if (cpu_sel) begin
         if (cpu_addr[ADDR_W-1:2] == '0)                sel = SEL_DATA;
         else if (cpu_addr[ADDR_W-1:2] == (ADDR_W-2)'(1)) sel = SEL_CTRL;
      end
   end

   assign rx_pop   = (sel == SEL_DATA) && !cpu_wr;
   assign tx_push  = (sel == SEL_DATA) && cpu_wr;
   assign rx_ready = !rx_full;
   assign tx_valid = !tx_empty;
   assign rx_take  = rx_valid && rx_ready;
   assign tx_give  = tx_valid && tx_ready;

   char_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n), .push(rx_valid), .wdata(rx_data), .pop(rx_pop),
      .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty));

   char_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(cpu_wdata[CHAR_W-1:0]),
      .pop(tx_ready), .head(tx_data), .count(tx_count), .full(tx_full),
      .empty(tx_empty));

   chan_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_wr((sel == SEL_CTRL) && cpu_wr),
      .wr_bits({cpu_wdata[ACT_BIT], cpu_wdata[EN_WR_BIT], cpu_wdata[EN_RD_BIT]}),
      .activity(rx_take || tx_give), .en_rd(en_rd), .en_wr(en_wr),
      .act_flag(act_flag));

   chan_irq #(.DEPTH(DEPTH)) u_irq (
      .en_rd(en_rd), .en_wr(en_wr), .rx_empty(rx_empty), .tx_count(tx_count),
      .tx_free(tx_free), .pend_rd(pend_rd), .pend_wr(pend_wr), .irq(irq));

   assign ravail = rx_empty ? 16'd0 : 16'(rx_count - CW'(1));

   always_comb begin
      cpu_rdata = '0;
      if (sel == SEL_DATA && !rx_empty) begin
         cpu_rdata[CHAR_W-1:0]     = rx_head;
         cpu_rdata[VALID_BIT]      = 1'b1;
         cpu_rdata[WORD_W-1:CNT_LSB] = ravail;
      end else if (sel == SEL_CTRL) begin
         cpu_rdata[EN_RD_BIT]        = en_rd;
         cpu_rdata[EN_WR_BIT]        = en_wr;
         cpu_rdata[PEND_RD_BIT]      = pend_rd;
         cpu_rdata[PEND_WR_BIT]      = pend_wr;
         cpu_rdata[ACT_BIT]          = act_flag;
         cpu_rdata[WORD_W-1:CNT_LSB] = 16'(tx_free);
      end
   end

   assert_rx_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == CW'(DEPTH)) |-> !rx_ready);
   assert_tx_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_count != '0));
   assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en_rd || en_wr));
   assert_ctrl_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel == SEL_CTRL) && !cpu_wr && !rx_valid && !tx_ready) |=>
         $stable(rx_count) && $stable(tx_count) && $stable({en_rd, en_wr}));
endmodule

// File: tb/byte_chan_regs_tb.sv
module byte_chan_regs_tb;
   localparam int DEPTH = 64;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
   logic [2:0]  cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, tx_ready = 1'b0, irq;
   logic [7:0]  tx_data;

   int tests = 0, fails = 0;
   bit done = 0;
   byte unsigned rxq[$];
   byte unsigned txq[$];
   bit m_re = 0, m_we = 0, m_ac = 0;

   always #2.5 clk = ~clk;

   byte_chan_regs u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_data();
      if (rxq.size() == 0) return 32'h0;
      return {16'(rxq.size() - 1), 1'b1, 7'b0, rxq[0]};
   endfunction

   function automatic logic [31:0] exp_ctrl();
      bit pr = m_re && rxq.size() > 0;
      bit pw = m_we && (DEPTH - txq.size()) >= DEPTH / 2;
      return {16'(DEPTH - txq.size()), 5'b0, m_ac, pw, pr, 6'b0, m_we, m_re};
   endfunction

   function automatic bit exp_irq();
      return (m_re && rxq.size() > 0) || (m_we && (DEPTH - txq.size()) >= DEPTH / 2);
   endfunction

   // op: 0 idle, 1 read data, 2 read control, 3 write data, 4 write control
   task automatic step(int op, logic [31:0] wd, bit rv, logic [7:0] rd, bit tr);
      bit racc, tacc;
      @(negedge clk);
      cpu_sel   = (op != 0);
      cpu_wr    = (op >= 3);
      cpu_addr  = (op == 2 || op == 4) ? 3'd4 : 3'd0;
      cpu_wdata = wd;
      rx_valid  = rv;
      rx_data   = rd;
      tx_ready  = tr;
      #1;
      chk("R6 rx_ready", 32'(rx_ready), 32'(rxq.size() < DEPTH));
      chk("R5 tx_valid", 32'(tx_valid), 32'(txq.size() > 0));
      chk("R8 irq", 32'(irq), 32'(exp_irq()));
      if (txq.size() > 0) chk("R5 tx_data order", 32'(tx_data), 32'(txq[0]));
      if (op == 1) chk(rxq.size() > 0 ? "R2 data read" : "R3 empty read",
                       cpu_rdata, exp_data());
      if (op == 2) chk("R7 R8 R9 R10 control read", cpu_rdata, exp_ctrl());
      racc = rv && rxq.size() < DEPTH;
      tacc = tr && txq.size() > 0;
      if (op == 1 && rxq.size() > 0) void'(rxq.pop_front());
      if (racc) rxq.push_back(rd);
      if (op == 3) begin
         bit room = txq.size() < DEPTH;
         if (tacc) void'(txq.pop_front());
         if (room) txq.push_back(wd[7:0]);
      end else if (tacc) void'(txq.pop_front());
      if (op == 4) begin m_re = wd[0]; m_we = wd[1]; end
      if (racc || tacc) m_ac = 1;
      else if (op == 4 && wd[10]) m_ac = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      #1;
      chk("R1 irq", 32'(irq), 0);
      chk("R1 rx_ready", 32'(rx_ready), 1);
      chk("R1 tx_valid", 32'(tx_valid), 0);
      step(2, 0, 0, 0, 0);
      chk("R1 control after reset", cpu_rdata, 32'h0040_0000);
      // R3 empty read has no effect
      step(1, 0, 0, 0, 0);
      step(2, 0, 0, 0, 0);
      // R7 enables, R8 write pending with empty tx queue
      step(4, 32'h3, 0, 0, 0);
      step(2, 0, 0, 0, 0);
      // R9 activity set and set-wins
      step(0, 0, 1, 8'hA5, 0);
      step(2, 0, 0, 0, 0);
      step(4, 32'h403, 1, 8'h5A, 0);
      step(2, 0, 0, 0, 0);
      step(4, 32'h403, 0, 0, 0);
      step(2, 0, 0, 0, 0);
      // R6 fill receive queue past capacity
      for (int i = 0; i < DEPTH + 4; i++) step(0, 0, 1, 8'(i * 7 + 3), 0);
      step(2, 0, 0, 0, 0);
      // R4 overfill transmit queue, R10 free space
      for (int i = 0; i < DEPTH + 5; i++) begin
         step(3, 32'(i + 8'h40), 0, 0, 0);
         if (i % 16 == 0) step(2, 0, 0, 0, 0);
      end
      step(2, 0, 0, 0, 0);
      // R11 control reads only
      for (int i = 0; i < 4; i++) step(2, 0, 0, 0, 0);
      // R2 drain receive queue, R5 drain transmit queue
      for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 0, 1);
      step(2, 0, 0, 0, 0);
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r = $urandom_range(0, 99);
         int op = (r < 30) ? 1 : (r < 45) ? 2 : (r < 80) ? 3 : (r < 88) ? 4 : 0;
         logic [31:0] wd = $urandom();
         step(op, wd, $urandom_range(0, 1) == 1, 8'($urandom()),
              $urandom_range(0, 2) == 0);
      end
      step(2, 0, 0, 0, 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule